// File: doc/BRIEF.md
# Multi-core interrupt distributor

This block routes interrupts for a four-core cluster and keeps each core's list of pending interrupts. Each external interrupt line has its own delivery setting. A static vector goes to a fixed set of cores chosen by a target mask. A dynamic vector goes either to every core or to one core picked at random. In random mode the mask lists the cores that may be picked. Cores also signal each other with typed inter-processor interrupts (IPIs): one type asks the target to reschedule, the other asks it to run a requested function.

Every core has a pending vector of `NVEC + 3` bits. External vector v is bit v. The core's own local interrupt is bit `NVEC`. A reschedule IPI is bit `NVEC+1` and a function-call IPI is bit `NVEC+2`. A pending bit stays set until the owning core acknowledges it through the acknowledge port. The external router is a two-state machine. In `RT_IDLE` it waits for captured requests and moves to `RT_ROUTE` when at least one is present, latching the lowest-numbered captured vector. In `RT_ROUTE` it computes the target set, delivers or drops the vector, and always returns to `RT_IDLE`. Random choices come from a free-running LFSR. The search starts at an LFSR-derived core index and steps round the cores, so masked-out cores are skipped.

Top module: `irq_dist`

## Requirements
- R1: After reset, every pending bit, every `core_irq` bit and `route_err` are 0, and every vector is static with target mask 4'b0001 (core 0 only).
- R2: A rising edge on `ext_irq[v]` is captured exactly once. Its pending bit v (at `core_pend[c*P+v]`, P = NVEC+3) appears on the targets three clock edges after the edge that samples the rise. A line held high does not deliver again.
- R3: A static vector is delivered to every core whose bit is set in its target mask, and to no other core.
- R4: A dynamic vector with the random bit clear is delivered to all cores, whatever its mask.
- R5: A static vector with an all-zero mask, or a random-mode vector with no eligible core, is dropped and sets `route_err`. `route_err` then stays 1 until reset.
- R6: A random-mode vector is delivered to exactly one core, and that core is always one whose mask bit is set.
- R7: An IPI sets bit NVEC+1 (`ipi_kind`=0, reschedule) or bit NVEC+2 (`ipi_kind`=1, function call) one edge later. It does so in every core named in `ipi_targets` except the sender `ipi_src`.
- R8: A high `core_local_irq[c]` sets bit NVEC of core c one edge later.
- R9: A pending bit stays set until an acknowledge for that core and bit index. That acknowledge clears it one edge later, and it leaves every other bit unchanged.
- R10: Sets that land on the same edge are never lost. An external vector and an IPI for the same core both become pending, and a set wins over an acknowledge of the same bit.
- R11: External rises sampled on the same edge are served lowest index first, each further vector arriving two edges after the one before.
- R12: `core_irq[c]` is 1 exactly when core c has any pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_vec | input | 3 | Vector being configured |
| cfg_wr_dynamic | input | 1 | 1 = dynamic delivery, 0 = static |
| cfg_wr_random | input | 1 | Dynamic sub-mode: 1 = one random core, 0 = all cores |
| cfg_wr_mask | input | 4 | Static targets, or eligible cores in random mode |
| ext_irq | input | 8 | External interrupt request lines |
| core_local_irq | input | 4 | Interrupt raised inside each core |
| ipi_valid | input | 1 | IPI send strobe |
| ipi_src | input | 2 | Sending core |
| ipi_targets | input | 4 | Target cores of the IPI |
| ipi_kind | input | 1 | 0 = reschedule, 1 = function call |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_core | input | 2 | Core acknowledging |
| ack_bit | input | 4 | Pending bit index being acknowledged |
| core_pend | output | 44 | Pending vectors, core c at [c*11 +: 11] |
| core_irq | output | 4 | Per-core interrupt request |
| route_err | output | 1 | Sticky dropped-vector flag |

## Verification
The results have fixed latencies. IPI, local-interrupt and acknowledge effects show one edge after the edge that samples them. An external vector shows three edges after its rise is sampled. A second vector that rose in the same cycle shows five edges after. The driver records each expected item with a due cycle equal to the drive cycle plus the latency for that path. The monitor compares whole pending vectors, `core_irq` and `route_err` on the falling edge of exactly that cycle. The random choice is checked only for one-hot delivery within the eligible mask.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

    typedef enum logic [0:0] {
        RT_IDLE  = 1'b0,
        RT_ROUTE = 1'b1
    } route_state_e;

    typedef struct packed {
        logic dyn;
        logic rnd;
    } vec_mode_t;

endpackage

// File: rtl/irq_cfg_bank.sv
module irq_cfg_bank
    import irq_dist_pkg::*;
#(
    parameter int NVEC  = 8,
    parameter int NCORE = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(NVEC)-1:0]  wr_vec,
    input  vec_mode_t                wr_mode,
    input  logic [NCORE-1:0]         wr_mask,
    input  logic [$clog2(NVEC)-1:0]  rd_vec,
    output vec_mode_t                rd_mode,
    output logic [NCORE-1:0]         rd_mask
);
    localparam int VW = $clog2(NVEC);

    vec_mode_t        mode_q [NVEC];
    logic [NCORE-1:0] mask_q [NVEC];

    for (genvar v = 0; v < NVEC; v++) begin : g_vec
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mode_q[v] <= '{dyn: 1'b0, rnd: 1'b0};
                mask_q[v] <= NCORE'(1);
            end else if (wr_en && wr_vec == VW'(v)) begin
                mode_q[v] <= wr_mode;
                mask_q[v] <= wr_mask;
            end
        end
    end

    assign rd_mode = mode_q[rd_vec];
    assign rd_mask = mask_q[rd_vec];

endmodule

// File: rtl/irq_lfsr.sv
module irq_lfsr #(
    parameter int          W    = 8,
    parameter logic [W-1:0] TAPS = 8'hB8,
    parameter logic [W-1:0] SEED = 8'hA5
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] value
);
    logic [W-1:0] sr_q;
    logic         fb;

    assign fb = ^(sr_q & TAPS);

    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= SEED;
        else        sr_q <= {sr_q[W-2:0], fb};
    end

    assign value = sr_q;

endmodule

// File: rtl/irq_route_fsm.sv
module irq_route_fsm
    import irq_dist_pkg::*;
#(
    parameter int NVEC  = 8,
    parameter int NCORE = 4,
    parameter int RW    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NVEC-1:0]          ext_irq,
    input  logic [RW-1:0]            rnd,
    output logic [$clog2(NVEC)-1:0]  cur_vec,
    input  vec_mode_t                cur_mode,
    input  logic [NCORE-1:0]         cur_mask,
    output logic                     dlv_valid,
    output logic [$clog2(NVEC)-1:0]  dlv_vec,
    output logic [NCORE-1:0]         dlv_mask,
    output logic                     dlv_rand,
    output logic                     drop,
    output route_state_e             state
);
    localparam int VW = $clog2(NVEC);

    route_state_e     state_q, state_d;
    logic [NVEC-1:0]  prev_q, hold_q, rise, clr;
    logic [VW-1:0]    vec_q, low_idx;
    logic             any_req;
    logic [NCORE-1:0] pick_oh, targets;

    assign rise    = ext_irq & ~prev_q;
    assign any_req = |hold_q;

    // lowest captured vector
    always_comb begin
        low_idx = '0;
        for (int i = NVEC - 1; i >= 0; i--) begin
            if (hold_q[i]) low_idx = VW'(i);
        end
    end

    // random single-core pick: rotate from an LFSR start, skip masked cores
    always_comb begin
        automatic int  start = int'(rnd) % NCORE;
        automatic bit  found = 1'b0;
        pick_oh = '0;
        for (int i = 0; i < NCORE; i++) begin
            automatic int idx = (start + i) % NCORE;
            if (!found && cur_mask[idx]) begin
                pick_oh[idx] = 1'b1;
                found        = 1'b1;
            end
        end
    end

    always_comb begin
        if (!cur_mode.dyn)     targets = cur_mask;
        else if (cur_mode.rnd) targets = pick_oh;
        else                   targets = '1;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RT_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RT_IDLE:  state_d = any_req ? RT_ROUTE : RT_IDLE;
            RT_ROUTE: state_d = RT_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        dlv_valid = 1'b0;
        dlv_mask  = '0;
        dlv_rand  = 1'b0;
        drop      = 1'b0;
        clr       = '0;
        unique case (state_q)
            RT_IDLE: ;
            RT_ROUTE: begin
                dlv_valid  = |targets;
                dlv_mask   = targets;
                dlv_rand   = cur_mode.dyn & cur_mode.rnd;
                drop       = ~|targets;
                clr[vec_q] = 1'b1;
            end
        endcase
    end

    // request capture and vector latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            hold_q <= '0;
            vec_q  <= '0;
        end else begin
            prev_q <= ext_irq;
            hold_q <= (hold_q & ~clr) | rise;
            if (state_q == RT_IDLE && any_req) vec_q <= low_idx;
        end
    end

    assign cur_vec = vec_q;
    assign dlv_vec = vec_q;
    assign state   = state_q;

endmodule

// File: rtl/irq_core_pend.sv
module irq_core_pend #(
    parameter int NVEC = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NVEC-1:0]            set_ext,
    input  logic                       set_local,
    input  logic                       set_resched,
    input  logic                       set_call,
    input  logic                       ack_en,
    input  logic [$clog2(NVEC+3)-1:0]  ack_bit,
    output logic [NVEC+2:0]            pend,
    output logic                       irq
);
    localparam int P = NVEC + 3;

    logic [P-1:0] pend_q, set_vec, ack_vec;

    assign set_vec = {set_call, set_resched, set_local, set_ext};
    assign ack_vec = ack_en ? (P'(1) << ack_bit) : '0;

    // a set in the same cycle as an acknowledge wins
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~ack_vec) | set_vec;
    end

    assign pend = pend_q;
    assign irq  = |pend_q;

endmodule

// File: rtl/irq_dist.sv
module irq_dist
    import irq_dist_pkg::*;
#(
    parameter int NVEC  = 8,
    parameter int NCORE = 4,
    parameter int RW    = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_wr_en,
    input  logic [$clog2(NVEC)-1:0]            cfg_wr_vec,
    input  logic                               cfg_wr_dynamic,
    input  logic                               cfg_wr_random,
    input  logic [NCORE-1:0]                   cfg_wr_mask,
    input  logic [NVEC-1:0]                    ext_irq,
    input  logic [NCORE-1:0]                   core_local_irq,
    input  logic                               ipi_valid,
    input  logic [$clog2(NCORE)-1:0]           ipi_src,
    input  logic [NCORE-1:0]                   ipi_targets,
    input  logic                               ipi_kind,
    input  logic                               ack_valid,
    input  logic [$clog2(NCORE)-1:0]           ack_core,
    input  logic [$clog2(NVEC+3)-1:0]          ack_bit,
    output logic [NCORE*(NVEC+3)-1:0]          core_pend,
    output logic [NCORE-1:0]                   core_irq,
    output logic                               route_err
);
    localparam int P  = NVEC + 3;
    localparam int VW = $clog2(NVEC);
    localparam int CW = $clog2(NCORE);

    logic [VW-1:0]    cur_vec, dlv_vec;
    vec_mode_t        cur_mode;
    logic [NCORE-1:0] cur_mask, dlv_mask;
    logic             dlv_valid, dlv_rand, drop, err_q;
    logic [RW-1:0]    rnd;
    route_state_e     rt_state;

    irq_cfg_bank #(.NVEC(NVEC), .NCORE(NCORE)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_vec  (cfg_wr_vec),
        .wr_mode ('{dyn: cfg_wr_dynamic, rnd: cfg_wr_random}),
        .wr_mask (cfg_wr_mask),
        .rd_vec  (cur_vec),
        .rd_mode (cur_mode),
        .rd_mask (cur_mask)
    );

    irq_lfsr #(.W(RW)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .value (rnd)
    );

    irq_route_fsm #(.NVEC(NVEC), .NCORE(NCORE), .RW(RW)) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_irq   (ext_irq),
        .rnd       (rnd),
        .cur_vec   (cur_vec),
        .cur_mode  (cur_mode),
        .cur_mask  (cur_mask),
        .dlv_valid (dlv_valid),
        .dlv_vec   (dlv_vec),
        .dlv_mask  (dlv_mask),
        .dlv_rand  (dlv_rand),
        .drop      (drop),
        .state     (rt_state)
    );

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        logic [NVEC-1:0] set_ext;
        logic            ipi_hit;

        assign set_ext = (dlv_valid && dlv_mask[c]) ? (NVEC'(1) << dlv_vec) : '0;
        assign ipi_hit = ipi_valid && ipi_targets[c] && (ipi_src != CW'(c));

        irq_core_pend #(.NVEC(NVEC)) u_pend (
            .clk         (clk),
            .rst_n       (rst_n),
            .set_ext     (set_ext),
            .set_local   (core_local_irq[c]),
            .set_resched (ipi_hit && !ipi_kind),
            .set_call    (ipi_hit && ipi_kind),
            .ack_en      (ack_valid && ack_core == CW'(c)),
            .ack_bit     (ack_bit),
            .pend        (core_pend[c*P +: P]),
            .irq         (core_irq[c])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    err_q <= 1'b0;
        else if (drop) err_q <= 1'b1;
    end

    assign route_err = err_q;

endmodule

// File: rtl/irq_dist_chk.sv
module irq_dist_chk
    import irq_dist_pkg::*;
#(
    parameter int NVEC  = 8,
    parameter int NCORE = 4
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            ipi_valid,
    input logic [$clog2(NCORE)-1:0]        ipi_src,
    input logic [NCORE-1:0]                ipi_targets,
    input logic                            ipi_kind,
    input logic                            ack_valid,
    input logic [$clog2(NCORE)-1:0]        ack_core,
    input logic [$clog2(NVEC+3)-1:0]       ack_bit,
    input logic [NCORE*(NVEC+3)-1:0]       core_pend,
    input logic                            route_err,
    input route_state_e                    rt_state,
    input logic                            dlv_valid,
    input logic                            dlv_rand,
    input logic [NCORE-1:0]                dlv_mask
);
    localparam int P  = NVEC + 3;
    localparam int CW = $clog2(NCORE);
    localparam int BW = $clog2(P);

    for (genvar c = 0; c < NCORE; c++) begin : g_c
        for (genvar b = 0; b < P; b++) begin : g_b
            p_hold_until_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
                core_pend[c*P+b] && !(ack_valid && ack_core == CW'(c) && ack_bit == BW'(b))
                |=> core_pend[c*P+b]);
        end

        p_resched_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ipi_valid && ipi_targets[c] && ipi_src != CW'(c) && !ipi_kind
            |=> core_pend[c*P+NVEC+1]);

        p_call_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ipi_valid && ipi_targets[c] && ipi_src != CW'(c) && ipi_kind
            |=> core_pend[c*P+NVEC+2]);
    end

    p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        route_err |=> route_err);

    p_route_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rt_state == RT_ROUTE |=> rt_state == RT_IDLE);

    p_random_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid && dlv_rand |-> $countones(dlv_mask) == 1);

endmodule

bind irq_dist irq_dist_chk #(.NVEC(NVEC), .NCORE(NCORE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ipi_valid   (ipi_valid),
    .ipi_src     (ipi_src),
    .ipi_targets (ipi_targets),
    .ipi_kind    (ipi_kind),
    .ack_valid   (ack_valid),
    .ack_core    (ack_core),
    .ack_bit     (ack_bit),
    .core_pend   (core_pend),
    .route_err   (route_err),
    .rt_state    (rt_state),
    .dlv_valid   (dlv_valid),
    .dlv_rand    (dlv_rand),
    .dlv_mask    (dlv_mask)
);

// File: tb/tb_irq_dist.sv
module tb_irq_dist;
    localparam int NV = 8;
    localparam int NC = 4;
    localparam int P  = NV + 3;
    localparam int PW = NC * P;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr_en = 1'b0;
    logic [2:0]    cfg_wr_vec = '0;
    logic          cfg_wr_dynamic = 1'b0;
    logic          cfg_wr_random = 1'b0;
    logic [NC-1:0] cfg_wr_mask = '0;
    logic [NV-1:0] ext_irq = '0;
    logic [NC-1:0] core_local_irq = '0;
    logic          ipi_valid = 1'b0;
    logic [1:0]    ipi_src = '0;
    logic [NC-1:0] ipi_targets = '0;
    logic          ipi_kind = 1'b0;
    logic          ack_valid = 1'b0;
    logic [1:0]    ack_core = '0;
    logic [3:0]    ack_bit = '0;
    logic [PW-1:0] core_pend;
    logic [NC-1:0] core_irq;
    logic          route_err;

    irq_dist dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_vec(cfg_wr_vec),
        .cfg_wr_dynamic(cfg_wr_dynamic), .cfg_wr_random(cfg_wr_random),
        .cfg_wr_mask(cfg_wr_mask), .ext_irq(ext_irq),
        .core_local_irq(core_local_irq), .ipi_valid(ipi_valid),
        .ipi_src(ipi_src), .ipi_targets(ipi_targets), .ipi_kind(ipi_kind),
        .ack_valid(ack_valid), .ack_core(ack_core), .ack_bit(ack_bit),
        .core_pend(core_pend), .core_irq(core_irq), .route_err(route_err)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    typedef struct {
        int            due;
        logic [PW-1:0] pend;
        logic [PW-1:0] care;
        logic          err;
        int            rvec;
        logic [NC-1:0] rmask;
        string         tag;
    } exp_t;

    exp_t          sb[$];
    logic [PW-1:0] model = '0;
    logic          err_model = 1'b0;

    function automatic int bi(int c, int b);
        return c * P + b;
    endfunction

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // driver side: push an expectation due lat cycles after the current one
    task automatic push(int lat, string tag, int rv = -1, logic [NC-1:0] rm = '0);
        exp_t it;
        int   k;
        it.due = cyc + lat; it.pend = model; it.err = err_model;
        it.rvec = rv; it.rmask = rm; it.tag = tag; it.care = '1;
        if (rv >= 0) for (int c = 0; c < NC; c++) it.care[bi(c, rv)] = 1'b0;
        k = sb.size();
        while (k > 0 && sb[k-1].due > it.due) k--;
        sb.insert(k, it);
    endtask

    // monitor: compare as results fall due
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t it;
            it = sb.pop_front();
            if (it.due < cyc) begin
                check(1'b0, {it.tag, " missed"}, 64'(it.due), 64'(cyc));
                continue;
            end
            check((core_pend & it.care) == (it.pend & it.care), it.tag,
                  64'(core_pend), 64'(it.pend));
            check(route_err == it.err, {it.tag, " R5 route_err"},
                  64'(route_err), 64'(it.err));
            if (it.rvec < 0) begin
                logic [NC-1:0] ei;
                for (int c = 0; c < NC; c++) ei[c] = |it.pend[c*P +: P];
                check(core_irq == ei, {it.tag, " R12 core_irq"}, 64'(core_irq), 64'(ei));
            end else begin
                logic [NC-1:0] got;
                for (int c = 0; c < NC; c++) got[c] = core_pend[bi(c, it.rvec)];
                check($countones(got) == 1 && (got & ~it.rmask) == '0,
                      {it.tag, " R6 random target"}, 64'(got), 64'(it.rmask));
            end
        end
    end

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic cfg(int v, bit dyn, bit rnd, logic [NC-1:0] m);
        cfg_wr_en = 1'b1; cfg_wr_vec = 3'(v);
        cfg_wr_dynamic = dyn; cfg_wr_random = rnd; cfg_wr_mask = m;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic ack_raw(int c, int b);
        ack_valid = 1'b1; ack_core = 2'(c); ack_bit = 4'(b);
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic ack(int c, int b, string tag);
        ack_valid = 1'b1; ack_core = 2'(c); ack_bit = 4'(b);
        model[bi(c, b)] = 1'b0;
        push(1, tag);
        @(negedge clk);
        ack_valid = 1'b0;
        drain();
    endtask

    task automatic ipi(int s, logic [NC-1:0] t, bit kind, string tag);
        ipi_valid = 1'b1; ipi_src = 2'(s); ipi_targets = t; ipi_kind = kind;
        for (int c = 0; c < NC; c++)
            if (t[c] && c != s) model[bi(c, kind ? NV+2 : NV+1)] = 1'b1;
        push(1, tag);
        @(negedge clk);
        ipi_valid = 1'b0;
        drain();
    endtask

    // static/broadcast delivery of vector v to cores in tm
    task automatic ext(int v, logic [NC-1:0] tm, string tag);
        ext_irq[v] = 1'b1;
        for (int c = 0; c < NC; c++) if (tm[c]) model[bi(c, v)] = 1'b1;
        push(3, tag);
        @(negedge clk);
        ext_irq[v] = 1'b0;
        drain();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model = '0; err_model = 1'b0;
        @(negedge clk);
        check(core_pend == '0, "R1 pend after reset", 64'(core_pend), 64'd0);
        check(core_irq == '0, "R1 core_irq after reset", 64'(core_irq), 64'd0);
        check(route_err == 1'b0, "R1 route_err after reset", 64'(route_err), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R1/R2: default routing to core 0
        ext(3, 4'b0001, "R1 R2 default static vec3");
        ack(0, 3, "R9 ack clears vec3");

        // R2: level held high delivers only once
        ext_irq[3] = 1'b1;
        model[bi(0, 3)] = 1'b1;
        push(3, "R2 held line first delivery");
        drain();
        ack(0, 3, "R9 ack held vec3");
        repeat (6) @(negedge clk);
        push(1, "R2 held line no redelivery");
        drain();
        ext_irq[3] = 1'b0;

        // R3: static multi-target
        cfg(1, 1'b0, 1'b0, 4'b1010);
        ext(1, 4'b1010, "R3 static mask 1010");
        ack(1, 1, "R9 ack core1 vec1 only");
        ack(3, 0, "R9 ack of clear bit leaves core3 vec1");

        // R4: dynamic broadcast ignores mask
        cfg(2, 1'b1, 1'b0, 4'b0001);
        ext(2, 4'b1111, "R4 broadcast all cores");

        // R6: random with single eligible core is deterministic
        cfg(4, 1'b1, 1'b1, 4'b0100);
        ext(4, 4'b0100, "R6 random only eligible core2");
        ack(2, 4, "R9 ack core2 vec4");

        // R6: random between cores 0 and 1
        cfg(4, 1'b1, 1'b1, 4'b0011);
        for (int i = 0; i < 8; i++) begin
            repeat (i) @(negedge clk);
            ext_irq[4] = 1'b1;
            push(3, "R6 random pick", 4, 4'b0011);
            @(negedge clk);
            ext_irq[4] = 1'b0;
            drain();
            ack_raw(0, 4);
            ack_raw(1, 4);
            push(1, "R9 random bit cleared");
            drain();
        end

        // R7: IPIs, sender excluded
        ipi(0, 4'b1110, 1'b0, "R7 reschedule to 1..3");
        ipi(2, 4'b1111, 1'b1, "R7 call excludes sender core2");

        // R8: local interrupt
        core_local_irq = 4'b0100;
        model[bi(2, NV)] = 1'b1;
        push(1, "R8 local irq core2");
        @(negedge clk);
        core_local_irq = '0;
        drain();

        // R10: external and IPI landing on the same edge for core 0
        ext_irq[5] = 1'b1;
        @(negedge clk);
        ext_irq[5] = 1'b0;
        @(negedge clk);
        ipi_valid = 1'b1; ipi_src = 2'd1; ipi_targets = 4'b0001; ipi_kind = 1'b0;
        model[bi(0, 5)] = 1'b1; model[bi(0, NV+1)] = 1'b1;
        push(1, "R10 ext and IPI same edge");
        @(negedge clk);
        ipi_valid = 1'b0;
        drain();

        // R10: set wins over ack of same bit (core1 reschedule already set)
        ipi_valid = 1'b1; ipi_src = 2'd0; ipi_targets = 4'b0010; ipi_kind = 1'b0;
        ack_valid = 1'b1; ack_core = 2'd1; ack_bit = 4'(NV+1);
        push(1, "R10 set beats ack");
        @(negedge clk);
        ipi_valid = 1'b0; ack_valid = 1'b0;
        drain();
        ack(1, NV+1, "R9 ack reschedule core1");

        // R11: two vectors rising together, lower first
        ext_irq = 8'b1100_0000;
        model[bi(0, 6)] = 1'b1;
        push(3, "R11 vec6 first");
        model[bi(0, 7)] = 1'b1;
        push(5, "R11 vec7 two cycles later");
        @(negedge clk);
        ext_irq = '0;
        drain();

        // R5: random with empty mask drops and flags
        cfg(4, 1'b1, 1'b1, 4'b0000);
        err_model = 1'b1;
        ext(4, 4'b0000, "R5 random empty mask dropped");
        repeat (4) @(negedge clk);
        push(1, "R5 route_err stays set");
        drain();

        // R1 again, then R5 static empty mask
        do_reset();
        ext(1, 4'b0001, "R1 config back to default");
        cfg(0, 1'b0, 1'b0, 4'b0000);
        err_model = 1'b1;
        ext(0, 4'b0000, "R5 static empty mask dropped");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule